// File: doc/BRIEF.md
# Integer ALU with Status Flags

This block is the arithmetic and logic stage of a small 16-bit processor datapath. A combinational path turns two operands, a 4-bit operation code and a byte/word size select into a result and a result write-enable. A registered flag block holds four status bits: zero, carry, sign and overflow. The carry bit stored in that block is the carry input for add-with-carry and subtract-with-borrow.

Operands must be the same size. In byte mode only the low eight bits of each operand are used, and the flags are taken from the byte result. Each operation updates the flags by its own rule. Compare and test set flags but write no result. Increment and decrement leave carry alone. The logic operations clear carry and overflow. Bitwise NOT touches no flag.

Top module: `alu16_top`

## Requirements
- R1: After reset all four flags are 0. Flags change only on a rising clock edge with `valid_i` high; when `valid_i` is low the flags hold and `wr_en_o` is 0.
- R2: Opcodes 0 add (a+b), 1 add-with-carry (a+b+C), 2 subtract (a−b) and 3 subtract-with-borrow (a−b−C) drive the wrapped result on `result_o` and raise `wr_en_o` while `valid_i` is high. C is the stored carry flag.
- R3: The carry flag (flags bit 2) is set on an unsigned carry out of an add, and on a borrow for subtract, subtract-with-borrow and compare.
- R4: The overflow flag (flags bit 0) is set when an arithmetic result is outside the signed range of the selected size.
- R5: The zero flag (bit 3) is set when the sized result is all zeros. The sign flag (bit 1) copies the result MSB.
- R6: Opcode 4 (compare) sets flags exactly as subtract does and holds `wr_en_o` low. Comparing 5 with 4 gives all four flags 0.
- R7: Opcodes 6 (increment, a+1) and 7 (decrement, a−1) update zero, sign and overflow and keep the previous carry flag.
- R8: Opcode 5 (negate) returns 0−a and sets carry unless a is zero. Opcode 11 (NOT) returns ~a, writes the result and leaves all flags unchanged.
- R9: Opcodes 8 (AND), 9 (OR) and 10 (XOR) write a&b, a|b and a^b. Opcode 12 (test) sets flags from a&b without writing. All four clear carry and overflow.
- R10: With `byte_i` high the operand bits 15:8 are ignored, `result_o[15:8]` is 0, and carry, sign and overflow come from bit 7.
- R11: Opcodes 13 to 15 write no result and leave all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 4 | Operation code |
| byte_i | input | 1 | 1 = 8-bit operation, 0 = 16-bit |
| a_i | input | 16 | Destination operand |
| b_i | input | 16 | Source operand |
| result_o | output | 16 | Combinational result |
| wr_en_o | output | 1 | Result write-enable |
| flags_o | output | 4 | Registered flags {zero, carry, sign, overflow} |

## Verification
Assertions check on every cycle that:
- the flags hold without a strobe;
- increment and decrement keep carry;
- the logic operations clear carry and overflow;
- compare and test never write;
- the upper result byte stays zero in byte mode;
- the zero flag follows the sized result.

Only the bench's sweep can show that sums, borrows and signed overflow are numerically correct. It runs every opcode at both sizes over corner operands with both carry-in values. It also covers the negate carry rule, that NOT leaves the flags alone, and the reserved opcodes.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBB  = 4'd3,
    OP_CMP  = 4'd4,
    OP_NEG  = 4'd5,
    OP_INC  = 4'd6,
    OP_DEC  = 4'd7,
    OP_AND  = 4'd8,
    OP_OR   = 4'd9,
    OP_XOR  = 4'd10,
    OP_NOT  = 4'd11,
    OP_TEST = 4'd12
  } alu_op_e;

  localparam int FLAG_Z = 3;
  localparam int FLAG_C = 2;
  localparam int FLAG_S = 1;
  localparam int FLAG_O = 0;
endpackage

// File: rtl/alu16_arith.sv
module alu16_arith
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [3:0]   op_i,
  input  logic         byte_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cf_o,
  output logic         of_o
);
  localparam int HW = W / 2;

  logic [W-1:0]  x, y;
  logic          ci, inv_c;
  logic [W:0]    full_sum;
  logic [HW:0]   low_sum;
  logic          co, xm, ym, rm;

  // operand steering: every arithmetic op maps onto a single adder
  always_comb begin
    x     = a_i;
    y     = b_i;
    ci    = 1'b0;
    inv_c = 1'b0;
    case (op_i)
      OP_ADC:         ci = cin_i;
      OP_SUB, OP_CMP: begin y = ~b_i; ci = 1'b1;   inv_c = 1'b1; end
      OP_SBB:         begin y = ~b_i; ci = ~cin_i; inv_c = 1'b1; end
      OP_NEG:         begin x = '0; y = ~a_i; ci = 1'b1; inv_c = 1'b1; end
      OP_INC:         begin y = '0; ci = 1'b1; end
      OP_DEC:         y = '1;
      default:        ;
    endcase
  end

  always_comb begin
    full_sum = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
    low_sum  = {1'b0, x[HW-1:0]} + {1'b0, y[HW-1:0]} + {{HW{1'b0}}, ci};
    if (byte_i) begin
      sum_o = {{(W-HW){1'b0}}, low_sum[HW-1:0]};
      co    = low_sum[HW];
      xm    = x[HW-1];
      ym    = y[HW-1];
      rm    = low_sum[HW-1];
    end else begin
      sum_o = full_sum[W-1:0];
      co    = full_sum[W];
      xm    = x[W-1];
      ym    = y[W-1];
      rm    = full_sum[W-1];
    end
    cf_o = co ^ inv_c;
    of_o = (xm == ym) && (rm != xm);
  end
endmodule

// File: rtl/alu16_logic.sv
module alu16_logic
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [3:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    case (op_i)
      OP_AND, OP_TEST: res_o = a_i & b_i;
      OP_OR:           res_o = a_i | b_i;
      OP_XOR:          res_o = a_i ^ b_i;
      OP_NOT:          res_o = ~a_i;
      default:         res_o = '0;
    endcase
  end
endmodule

// File: rtl/alu16_flags.sv
module alu16_flags
  import alu16_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       upd_zso_i,
  input  logic       upd_c_i,
  input  logic [3:0] nxt_i,
  output logic [3:0] flags_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic [3:0] flags_q, flags_d;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    flags_d = flags_q;
    if (upd_zso_i) begin
      flags_d[FLAG_Z] = nxt_i[FLAG_Z];
      flags_d[FLAG_S] = nxt_i[FLAG_S];
      flags_d[FLAG_O] = nxt_i[FLAG_O];
    end
    if (upd_c_i) flags_d[FLAG_C] = nxt_i[FLAG_C];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)                flags_q <= 4'b0000;
    else if (upd_zso_i || upd_c_i) flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_zso_i && !upd_c_i) |=> $stable(flags_o));

  p_carry_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_zso_i && !upd_c_i) |=> (flags_o[FLAG_C] == $past(flags_o[FLAG_C])));
endmodule

// File: rtl/alu16_top.sv
module alu16_top
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid_i,
  input  logic [3:0]   op_i,
  input  logic         byte_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] result_o,
  output logic         wr_en_o,
  output logic [3:0]   flags_o
);
  localparam int HW = W / 2;

  logic [W-1:0] arith_res, logic_res, raw_res;
  logic         arith_cf, arith_of;
  logic         is_arith, is_logic, is_incdec, no_write;
  logic [3:0]   nxt_flags;
  logic         upd_zso, upd_c, msb;

  alu16_arith #(.W(W)) arith_i (
    .op_i(op_i), .byte_i(byte_i), .a_i(a_i), .b_i(b_i),
    .cin_i(flags_o[FLAG_C]), .sum_o(arith_res), .cf_o(arith_cf), .of_o(arith_of)
  );

  alu16_logic #(.W(W)) logic_i (
    .op_i(op_i), .a_i(a_i), .b_i(b_i), .res_o(logic_res)
  );

  always_comb begin
    is_arith  = (op_i <= OP_DEC);
    is_logic  = (op_i == OP_AND) || (op_i == OP_OR) || (op_i == OP_XOR) || (op_i == OP_TEST);
    is_incdec = (op_i == OP_INC) || (op_i == OP_DEC);
    no_write  = (op_i == OP_CMP) || (op_i == OP_TEST) || (op_i > OP_TEST);
    raw_res   = is_arith ? arith_res : logic_res;
    result_o  = byte_i ? {{(W-HW){1'b0}}, raw_res[HW-1:0]} : raw_res;
    msb       = byte_i ? result_o[HW-1] : result_o[W-1];
    wr_en_o   = valid_i && !no_write;
    nxt_flags[FLAG_Z] = (result_o == '0);
    nxt_flags[FLAG_S] = msb;
    nxt_flags[FLAG_C] = is_arith ? arith_cf : 1'b0;
    nxt_flags[FLAG_O] = is_arith ? arith_of : 1'b0;
    upd_zso   = valid_i && (is_arith || is_logic);
    upd_c     = upd_zso && !is_incdec;
  end

  alu16_flags flags_i (
    .clk(clk), .rst_n(rst_n), .upd_zso_i(upd_zso), .upd_c_i(upd_c),
    .nxt_i(nxt_flags), .flags_o(flags_o)
  );

  p_nowrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_CMP || op_i == OP_TEST) |-> !wr_en_o);

  p_logic_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && is_logic) |=> (!flags_o[FLAG_C] && !flags_o[FLAG_O]));

  p_byte_upper_r10: assert property (@(posedge clk) disable iff (!rst_n)
    byte_i |-> (result_o[W-1:HW] == '0));

  p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && (is_arith || is_logic)) |=> (flags_o[FLAG_Z] == ($past(result_o) == '0)));
endmodule

// File: tb/alu16_top_tb_top.sv
module alu16_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid_i;
  logic [3:0]  op_i;
  logic        byte_i;
  logic [15:0] a_i, b_i;
  logic [15:0] result_o;
  logic        wr_en_o;
  logic [3:0]  flags_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  alu16_top dut_i (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i), .byte_i(byte_i),
    .a_i(a_i), .b_i(b_i), .result_o(result_o), .wr_en_o(wr_en_o), .flags_o(flags_o)
  );

  function automatic logic [15:0] corner(input int k);
    case (k)
      0: return 16'h0000;  1: return 16'h0001;  2: return 16'h0002;  3: return 16'h007F;
      4: return 16'h0080;  5: return 16'h0081;  6: return 16'h00FF;  7: return 16'h0100;
      8: return 16'h7FFF;  9: return 16'h8000; 10: return 16'h8001; 11: return 16'hFFFF;
      12: return 16'h1234; 13: return 16'hFEDC; 14: return 16'h5555; default: return 16'hAAAA;
    endcase
  endfunction

  function automatic string tag_of(input int op);
    if (op <= 3) return "R2";
    if (op == 4) return "R6";
    if (op == 5 || op == 11) return "R8";
    if (op == 6 || op == 7) return "R7";
    if (op <= 12) return "R9";
    return "R11";
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // one operation with a strobe, applied at the falling edge
  task automatic drive(input int op, input logic [15:0] a, input logic [15:0] b, input bit byt, input bit v);
    valid_i = v; op_i = op[3:0]; a_i = a; b_i = b; byte_i = byt;
  endtask

  task automatic run_vec(input int op, input logic [15:0] a, input logic [15:0] b, input int c, input bit byt);
    int m, sb, ua, ub, sa, sbv, sv, d, r, ci;
    bit cf, of, wr, fl_kept;
    logic [3:0] prev, expf;
    // set carry = c via a word add: FFFF+1 -> {Z1,C1,S0,O0}; 0+0 -> {Z1,C0,S0,O0}
    drive(0, (c != 0) ? 16'hFFFF : 16'h0000, (c != 0) ? 16'h0001 : 16'h0000, 0, 1);
    @(negedge clk);
    prev = {1'b1, c[0], 1'b0, 1'b0};
    m  = byt ? 'hFF : 'hFFFF;
    sb = byt ? 'h80 : 'h8000;
    ua = int'(a) & m; ub = int'(b) & m;
    sa  = (ua >= sb) ? ua - 2*sb : ua;
    sbv = (ub >= sb) ? ub - 2*sb : ub;
    cf = 0; of = 0; wr = 1; fl_kept = 0; sv = 0; r = 0;
    case (op)
      0, 1: begin ci = (op == 1) ? c : 0; d = ua + ub + ci; r = d & m; cf = d > m; sv = sa + sbv + ci; end
      2, 3, 4: begin ci = (op == 3) ? c : 0; d = ua - ub - ci; r = d & m; cf = d < 0; sv = sa - sbv - ci; end
      5: begin r = (0 - ua) & m; cf = ua != 0; sv = -sa; end
      6: begin r = (ua + 1) & m; cf = c[0]; sv = sa + 1; end
      7: begin r = (ua - 1) & m; cf = c[0]; sv = sa - 1; end
      8, 12: r = ua & ub;
      9: r = ua | ub;
      10: r = ua ^ ub;
      11: begin r = (~ua) & m; fl_kept = 1; end
      default: begin r = -1; fl_kept = 1; wr = 0; end
    endcase
    if (op <= 7) of = (sv > sb - 1) || (sv < -sb);
    if (op == 4 || op == 12) wr = 0;
    // R5 zero/sign from the sized result; R3 carry; R4 overflow
    expf = fl_kept ? prev : {r == 0, cf, r >= sb, of};
    drive(op, a, b, byt, 1);
    #1;
    check(tag_of(op), byt ? "wr_en R10" : "wr_en", int'(wr_en_o), int'(wr));
    if (r >= 0) check(tag_of(op), byt ? "result R10" : "result", int'(result_o), r);
    @(negedge clk);
    check(tag_of(op), byt ? "flags R3 R4 R5 R10" : "flags R3 R4 R5", int'(flags_o), int'(expf));
  endtask

  initial begin
    rst_n = 1'b0;
    drive(0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "reset flags", int'(flags_o), 0);

    // R1: no strobe, flags hold
    drive(0, 16'hFFFF, 16'h0001, 0, 1);
    @(negedge clk);
    drive(0, 16'h0001, 16'h0001, 0, 0);
    #1 check("R1", "wr_en without strobe", int'(wr_en_o), 0);
    @(negedge clk);
    check("R1", "flags held without strobe", int'(flags_o), 'b1100);

    // R6: compare 5 with 4 -> all flags clear
    drive(4, 16'd5, 16'd4, 0, 1);
    @(negedge clk);
    check("R6", "cmp 5,4 flags", int'(flags_o), 0);

    for (int op = 0; op < 16; op++)
      for (int byt = 0; byt < 2; byt++)
        for (int c = 0; c < 2; c++)
          for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++)
              run_vec(op, corner(i), corner(j), c, byt[0]);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired act=0 exp=1");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule